// File: doc/BRIEF.md
# Shift-and-Add Result Output Stage

This block sits behind a bank of eight multiply-accumulate cells. Each cell has a 26-bit accumulator. A registered 3-bit address picks one cell. The block either shows that cell's value on a 26-bit result bus, or folds it into a 26-bit output-stage accumulator. When folding, the accumulator first takes its previous value shifted arithmetically right by 8 bits and then adds the new value. This combines the partial results of passes that split a wide operand into 8-bit slices.

While the address stays the same, the block keeps the value it captured on the first clock of that address. Later changes to that cell's accumulator do not reach the output, so a slow reader sees a stable word. The result bus has a 10-bit upper field and a 16-bit lower field, each with its own active-low enable. The block also decodes the clear strobe sent back to the cells: either the addressed cell alone or all eight at once.

Top module: `sas_result_stage`

## Requirements
- R1: `addr_i` and `shadd_i` are registered on each rising edge. The cell selected by the registered address is sampled at the next edge. The result bus therefore shows a newly addressed cell two rising edges after the address is presented.
- R2: When the registered shift-add control is 0, the result bus shows the captured cell value.
- R3: When the registered shift-add control is 0, the output-stage accumulator is loaded with the captured cell value. When it is 1, the accumulator becomes the captured value plus its previous value shifted arithmetically right by 8 (sign copied into bits 25..18), wrapping modulo 2^26. In that case the result bus shows the accumulator.
- R4: While the registered address equals its previous registered value, the captured value does not change, whatever the cell accumulators do.
- R5: `sum_o[25:16]` carries the result when `hi_en_n` is 0 and is zero otherwise. `sum_o[15:0]` likewise follows `lo_en_n`. `hi_vld_o` and `lo_vld_o` are the inverted enables. Both fields may be on together.
- R6: With `erase_n` 0 and `rst_n` 1, `clr_o` is one-hot at the bit given by the registered address. With both 0, `clr_o` is all ones. With `erase_n` 1, `clr_o` is zero.
- R7: A rising edge with `rst_n` 0 clears the registered address, the shift-add control, the captured value and the accumulator to zero. The first address after reset always counts as new.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also widens the clear to all cells |
| erase_n | input | 1 | Active-low cell clear request |
| addr_i | input | 3 | Cell select |
| shadd_i | input | 1 | 1 = shift-add into output accumulator and show it |
| hi_en_n | input | 1 | Active-low enable of result bits 25..16 |
| lo_en_n | input | 1 | Active-low enable of result bits 15..0 |
| cell_acc_i | input | 208 | Eight 26-bit cell accumulators, cell k at bits 26k+25..26k |
| sum_o | output | 26 | Result bus |
| hi_vld_o | output | 1 | Upper field driven |
| lo_vld_o | output | 1 | Lower field driven |
| clr_o | output | 8 | Clear strobe, one bit per cell |

## Verification
The address and shift-add control reach the result bus two rising edges after they are presented: one edge to register them and one to capture or accumulate. The field enables and the clear strobe are combinational on the current inputs and the registered address. The bench keeps its own model, which it updates on the same rising edges as the design. It changes inputs and compares all outputs only at falling edges, so each comparison sees the state after exactly the edges counted. Directed cases cover a negative partial sum that must shift in sign bits, a held address while the cell values keep changing, and clears applied with and without reset.

// File: rtl/sas_pkg.sv
package sas_pkg;
    typedef enum logic {VIEW_CELL = 1'b0, VIEW_SUM = 1'b1} view_e;
endpackage

// File: rtl/sas_select.sv
module sas_select #(
    parameter int NCELL = 8,
    parameter int W     = 26,
    parameter int AW    = $clog2(NCELL)
) (
    input  logic [NCELL*W-1:0] cells_i,
    input  logic [AW-1:0]      addr_i,
    output logic [W-1:0]       sel_o
);
    logic [W-1:0] arr [NCELL];
    for (genvar k = 0; k < NCELL; k++) begin : g_unpack
        assign arr[k] = cells_i[k*W +: W];
    end
    assign sel_o = arr[addr_i];
endmodule

// File: rtl/sas_clear.sv
module sas_clear #(
    parameter int NCELL = 8,
    parameter int AW    = $clog2(NCELL)
) (
    input  logic             erase_n,
    input  logic             all_n,
    input  logic [AW-1:0]    addr_i,
    output logic [NCELL-1:0] clr_o
);
    for (genvar k = 0; k < NCELL; k++) begin : g_bit
        assign clr_o[k] = !erase_n && (!all_n || (addr_i == AW'(k)));
    end
endmodule

// File: rtl/sas_result_stage.sv
module sas_result_stage
    import sas_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int W     = 26,
    parameter int SHIFT = 8,
    parameter int SPLIT = 16,
    parameter int AW    = $clog2(NCELL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               erase_n,
    input  logic [AW-1:0]      addr_i,
    input  logic               shadd_i,
    input  logic               hi_en_n,
    input  logic               lo_en_n,
    input  logic [NCELL*W-1:0] cell_acc_i,
    output logic [W-1:0]       sum_o,
    output logic               hi_vld_o,
    output logic               lo_vld_o,
    output logic [NCELL-1:0]   clr_o
);
    localparam int HIW = W - SPLIT;

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic           newa;
        logic           started;
        logic           shadd;
        view_e          view;
        logic [W-1:0]   cap;
        logic signed [W-1:0] acc;
    } state_t;

    state_t s_q, s_d;
    logic [W-1:0] sel, pick, shown;

    sas_select #(.NCELL(NCELL), .W(W), .AW(AW)) u_sel (
        .cells_i(cell_acc_i), .addr_i(s_q.addr), .sel_o(sel));

    sas_clear #(.NCELL(NCELL), .AW(AW)) u_clr (
        .erase_n(erase_n), .all_n(rst_n), .addr_i(s_q.addr), .clr_o(clr_o));

    always_comb begin
        s_d         = s_q;
        s_d.addr    = addr_i;
        s_d.shadd   = shadd_i;
        s_d.started = 1'b1;
        s_d.newa    = !s_q.started || (addr_i != s_q.addr);
        pick        = s_q.newa ? sel : s_q.cap;
        s_d.cap     = pick;
        if (s_q.shadd) begin
            s_d.acc  = $signed(pick) + (s_q.acc >>> SHIFT);
            s_d.view = VIEW_SUM;
        end else begin
            s_d.acc  = $signed(pick);
            s_d.view = VIEW_CELL;
        end
        shown = (s_q.view == VIEW_SUM) ? s_q.acc : s_q.cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sum_o    = {(hi_en_n ? {HIW{1'b0}} : shown[W-1:SPLIT]),
                       (lo_en_n ? {SPLIT{1'b0}} : shown[SPLIT-1:0])};
    assign hi_vld_o = !hi_en_n;
    assign lo_vld_o = !lo_en_n;

    AST_NEW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.newa |=> (s_q.cap == $past(sel)));                       // R1
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.newa && s_q.started) |=> $stable(s_q.cap));            // R4
    AST_LOAD_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.shadd |=> (s_q.acc == s_q.cap));                        // R3
    AST_HI_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en_n |-> (sum_o[W-1:SPLIT] == '0));                       // R5
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_n |-> ($countones(clr_o) == 1));                      // R6
endmodule

// File: tb/sas_result_stage_test.sv
module sas_result_stage_test;
    localparam int N = 8;
    localparam int W = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0, erase_n = 1'b1, shadd = 1'b0, hi_en_n = 1'b0, lo_en_n = 1'b0;
    logic [2:0] addr = '0;
    logic [N*W-1:0] cells = '0;
    logic [W-1:0] sum;
    logic hi_vld, lo_vld;
    logic [N-1:0] clr;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    sas_result_stage uut (
        .clk(clk), .rst_n(rst_n), .erase_n(erase_n), .addr_i(addr), .shadd_i(shadd),
        .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .cell_acc_i(cells),
        .sum_o(sum), .hi_vld_o(hi_vld), .lo_vld_o(lo_vld), .clr_o(clr));

    // independent model of the requirements
    logic [2:0]   m_addr;
    logic         m_new, m_started, m_shadd, m_view;
    logic [W-1:0] m_cap, m_acc;

    function automatic logic [W-1:0] asr8(input logic [W-1:0] v);
        return W'($signed(v) >>> 8);
    endfunction

    function automatic logic [W-1:0] cell_of(input logic [N*W-1:0] c, input logic [2:0] a);
        return c[a*W +: W];
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] p;
        if (!rst_n) begin
            m_addr <= '0; m_new <= 1'b0; m_started <= 1'b0; m_shadd <= 1'b0;
            m_view <= 1'b0; m_cap <= '0; m_acc <= '0;
        end else begin
            p = m_new ? cell_of(cells, m_addr) : m_cap;
            m_cap <= p;
            m_acc <= m_shadd ? p + asr8(m_acc) : p;
            m_view <= m_shadd;
            m_new <= !m_started || (addr != m_addr);
            m_started <= 1'b1;
            m_addr <= addr;
            m_shadd <= shadd;
        end
    end

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ports();
        logic [W-1:0] r, e;
        logic [N-1:0] ec;
        r = m_view ? m_acc : m_cap;
        e = {(hi_en_n ? 10'd0 : r[25:16]), (lo_en_n ? 16'd0 : r[15:0])};
        check(sum === e, m_view ? "R3" : "R2", sum, e);
        check(hi_vld === !hi_en_n && lo_vld === !lo_en_n, "R5",
              W'({hi_vld, lo_vld}), W'({!hi_en_n, !lo_en_n}));
        ec = erase_n ? '0 : (!rst_n ? '1 : N'(1) << m_addr);
        check(clr === ec, "R6", W'(clr), W'(ec));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_ports();
    endtask

    task automatic rand_cells();
        for (int k = 0; k < N; k++) cells[k*W +: W] = W'($urandom);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] first;
        void'($urandom(32'h5A17));
        rand_cells();
        repeat (3) @(negedge clk);
        // R7: reset state, outputs zero, clear with reset widens to all cells (R6)
        tick();
        check(sum === '0, "R7", sum, '0);
        erase_n = 1'b0;
        #1;
        check(clr === '1, "R6", W'(clr), W'(8'hFF));
        erase_n = 1'b1;
        rst_n = 1'b1;

        // R1 + R3: negative partial shifted with sign, then added
        cells = '0;
        cells[0*W +: W] = 26'h3FF0000;
        cells[1*W +: W] = 26'h0000100;
        addr = 3'd0; shadd = 1'b0;
        tick();
        addr = 3'd1; shadd = 1'b1;
        tick();
        check(sum === 26'h3FF0000, "R1", sum, 26'h3FF0000);
        tick();
        check(sum === 26'h0000000, "R3", sum, 26'h0000000);

        // R4: hold while address unchanged and cells change
        shadd = 1'b0; addr = 3'd5;
        cells[5*W +: W] = 26'h1234567;
        tick();
        tick();
        first = sum;
        check(first === 26'h1234567, "R1", first, 26'h1234567);
        for (int i = 0; i < 4; i++) begin
            rand_cells();
            tick();
            check(sum === first, "R4", sum, first);
        end

        // R5: field enables
        hi_en_n = 1'b1; lo_en_n = 1'b0; #1;
        check(sum === {10'd0, first[15:0]}, "R5", sum, {10'd0, first[15:0]});
        hi_en_n = 1'b0; lo_en_n = 1'b1; #1;
        check(sum === {first[25:16], 16'd0}, "R5", sum, {first[25:16], 16'd0});
        lo_en_n = 1'b0;

        // R6: addressed clear
        erase_n = 1'b0; #1;
        check(clr === 8'b0010_0000, "R6", W'(clr), W'(8'b0010_0000));
        erase_n = 1'b1;

        // random mix
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(3) != 0) addr = 3'($urandom);
            shadd   = 1'($urandom);
            erase_n = ($urandom_range(7) != 0);
            hi_en_n = ($urandom_range(3) == 0);
            lo_en_n = ($urandom_range(3) == 0);
            rand_cells();
            if (i == 300) rst_n = 1'b0;
            if (i == 302) rst_n = 1'b1;
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule